// File: doc/BRIEF.md
# Single-Bit Boolean Processing Unit

This unit carries out single-bit operations for an 8-bit controller datapath. It takes one request at a time, made of an operation code and an 8-bit bit address. It turns the bit address into a byte location and a bit position in data memory. It then reads that byte, and for operations that modify the bit it writes the byte back one cycle later with only the addressed bit changed. The carry flag is held inside the unit and acts as a 1-bit accumulator. Loads, AND, OR and inverted-operand AND/OR fold a memory bit into it, and a store copies it into a memory bit.

The lower half of the bit space selects bits in a 16-byte window of internal RAM. The upper half selects bits in the control registers whose byte addresses are multiples of 8. Three bit addresses in that upper half behave as follows:
- Address 0xD3 is an ordinary memory bit.
- Address 0xD4 is an ordinary memory bit.
- Address 0xD7 is the carry flag itself. The unit serves it without touching memory.

Every request reports the old value of the addressed bit on `bit_out` during its completion cycle, which the surrounding sequencer uses for conditional branches. The test-and-clear operation returns the old bit and clears it in the same read-modify-write, so no other access can come in between.

Top module: `bitproc_core`

## Requirements
- R1: A bit address 0x00-0x7F reads byte 0x20 + (address >> 3), bit position = address[2:0].
- R2: A bit address 0x80-0xFF (other than 0xD7) reads byte (address & 0xF8), bit position = address[2:0]; 0xD3 and 0xD4 are ordinary memory bits.
- R3: A request is accepted when `req_valid` is high and `busy` is low. In that cycle `mem_rd_en` is high with the mapped byte on `mem_rd_addr`. In the next cycle `busy` is high and any request presented is ignored.
- R4: For op 0 (set), op 1 (clear) and op 2 (complement), the cycle after acceptance drives `mem_wr_en`. `mem_wr_mask` has the one bit of the target position set. `mem_wr_data` equals the read byte with only that bit set, cleared or inverted.
- R5: Op 4 (store carry) writes the current carry value into the target bit.
- R6: These ops update the carry at the end of the cycle after acceptance and write nothing to memory:
  - op 3 loads the bit into the carry;
  - op 5 ANDs the bit into the carry;
  - op 6 ORs the bit into the carry;
  - op 7 ANDs the inverted bit into the carry;
  - op 8 ORs the inverted bit into the carry.
  No other op changes the carry.
- R7: Op 9 (test-and-clear) reports the old bit on `bit_out` and writes the byte back with that bit cleared, whatever its old value.
- R8: Op 10 (test) and the unused codes 11-15 report the old bit on `bit_out`, write nothing and leave the carry unchanged.
- R9: Bit address 0xD7 targets the carry flag. No memory read or write happens, and every op acts on the carry as its bit.
- R10: During reset `busy`, `done`, `mem_wr_en` and `carry` are low.
- R11: `done` is high exactly in the cycle after acceptance. `bit_out` then carries the old value of the addressed bit for every op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 4 | Operation code |
| req_bit | input | 8 | Bit address |
| busy | output | 1 | Second phase in progress; new requests ignored |
| mem_rd_en | output | 1 | Data memory read strobe (data returns next cycle) |
| mem_rd_addr | output | 8 | Byte address of read |
| mem_rd_data | input | 8 | Byte returned by data memory one cycle after the strobe |
| mem_wr_en | output | 1 | Data memory write strobe |
| mem_wr_addr | output | 8 | Byte address of write |
| mem_wr_mask | output | 8 | One-hot mask of the bit being written |
| mem_wr_data | output | 8 | Byte written back |
| done | output | 1 | Request completes this cycle |
| bit_out | output | 1 | Old value of the addressed bit, valid with `done` |
| carry | output | 1 | Boolean accumulator (carry flag) |

## Verification
A wrong captured address or position shows up in the completion cycle, one cycle after acceptance. It appears as a wrong write byte, a wrong mask or a wrong `bit_out`, and from then on as a bench memory image that differs from the model's image. A corrupted carry is visible on the `carry` port at once. It also spreads into later store, AND and OR results within a few requests. A stuck phase flag either drops the second half of a request or accepts a request during `busy`. Each of these breaks the expected read and write strobes in the very next cycle.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;
  localparam int BIT_ADDR_W = 8;
  localparam int BYTE_W     = 8;
  localparam int POS_W      = $clog2(BYTE_W);
  localparam int OP_W       = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SET     = 4'd0,
    OP_CLR     = 4'd1,
    OP_FLIP    = 4'd2,
    OP_LOAD_C  = 4'd3,
    OP_STORE_C = 4'd4,
    OP_AND     = 4'd5,
    OP_OR      = 4'd6,
    OP_ANDN    = 4'd7,
    OP_ORN     = 4'd8,
    OP_TAKE    = 4'd9,
    OP_TEST    = 4'd10
  } bit_op_e;

  typedef struct packed {
    logic [BIT_ADDR_W-1:0] byte_addr;
    logic [POS_W-1:0]      pos;
    logic                  to_carry;
  } bit_loc_t;
endpackage

// File: rtl/bitproc_rst_sync.sv
module bitproc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bitproc_addr_map.sv
module bitproc_addr_map
  import bitproc_pkg::*;
#(
  parameter logic [BIT_ADDR_W-1:0] RAM_BASE   = 8'h20,
  parameter logic [BIT_ADDR_W-1:0] CARRY_ADDR = 8'hD7
) (
  input  logic [BIT_ADDR_W-1:0] bit_addr,
  output bit_loc_t              loc
);
  localparam int IDX_W = BIT_ADDR_W - 1 - POS_W;

  logic [IDX_W-1:0] ram_idx;

  always_comb begin
    ram_idx      = bit_addr[BIT_ADDR_W-2:POS_W];
    loc.pos      = bit_addr[POS_W-1:0];
    loc.to_carry = (bit_addr == CARRY_ADDR);
    if (bit_addr[BIT_ADDR_W-1]) begin
      // register half: byte is the address rounded down to a multiple of 8
      loc.byte_addr = {bit_addr[BIT_ADDR_W-1:POS_W], {POS_W{1'b0}}};
    end else begin
      // RAM half: 16-byte window starting at RAM_BASE
      loc.byte_addr = RAM_BASE + BIT_ADDR_W'(ram_idx);
    end
  end
endmodule

// File: rtl/bitproc_alu.sv
module bitproc_alu
  import bitproc_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            old_bit,
  input  logic            carry_in,
  output logic            write_bit,
  output logic            new_bit,
  output logic            new_carry
);
  always_comb begin
    write_bit = 1'b0;
    new_bit   = old_bit;
    new_carry = carry_in;
    case (op)
      OP_SET:     begin write_bit = 1'b1; new_bit = 1'b1;     end
      OP_CLR:     begin write_bit = 1'b1; new_bit = 1'b0;     end
      OP_FLIP:    begin write_bit = 1'b1; new_bit = ~old_bit; end
      OP_STORE_C: begin write_bit = 1'b1; new_bit = carry_in; end
      OP_TAKE:    begin write_bit = 1'b1; new_bit = 1'b0;     end
      OP_LOAD_C:  new_carry = old_bit;
      OP_AND:     new_carry = carry_in & old_bit;
      OP_OR:      new_carry = carry_in | old_bit;
      OP_ANDN:    new_carry = carry_in & ~old_bit;
      OP_ORN:     new_carry = carry_in | ~old_bit;
      default:    ; // test and unused codes: observe only
    endcase
  end
endmodule

// File: rtl/bitproc_core.sv
module bitproc_core
  import bitproc_pkg::*;
#(
  parameter logic [BIT_ADDR_W-1:0] RAM_BASE   = 8'h20,
  parameter logic [BIT_ADDR_W-1:0] CARRY_ADDR = 8'hD7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [OP_W-1:0]       req_op,
  input  logic [BIT_ADDR_W-1:0] req_bit,
  output logic                  busy,
  output logic                  mem_rd_en,
  output logic [BIT_ADDR_W-1:0] mem_rd_addr,
  input  logic [BYTE_W-1:0]     mem_rd_data,
  output logic                  mem_wr_en,
  output logic [BIT_ADDR_W-1:0] mem_wr_addr,
  output logic [BYTE_W-1:0]     mem_wr_mask,
  output logic [BYTE_W-1:0]     mem_wr_data,
  output logic                  done,
  output logic                  bit_out,
  output logic                  carry
);
  logic rst_n_sync;

  bitproc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // ---------------- state ----------------
  logic            busy_q, busy_d;
  logic            carry_q, carry_d;
  logic [OP_W-1:0] op_q, op_d;
  bit_loc_t        loc_q, loc_d;

  bit_loc_t req_loc;
  logic     accept;
  logic     old_bit, alu_write, alu_bit, alu_carry;
  logic [BYTE_W-1:0] pos_mask;

  bitproc_addr_map #(.RAM_BASE(RAM_BASE), .CARRY_ADDR(CARRY_ADDR)) u_map (
    .bit_addr (req_bit),
    .loc      (req_loc)
  );

  assign old_bit = loc_q.to_carry ? carry_q : mem_rd_data[loc_q.pos];

  bitproc_alu u_alu (
    .op        (op_q),
    .old_bit   (old_bit),
    .carry_in  (carry_q),
    .write_bit (alu_write),
    .new_bit   (alu_bit),
    .new_carry (alu_carry)
  );

  // ---------------- next state ----------------
  always_comb begin
    accept  = req_valid & ~busy_q;
    busy_d  = accept;
    op_d    = accept ? req_op  : op_q;
    loc_d   = accept ? req_loc : loc_q;
    carry_d = carry_q;
    if (busy_q) begin
      if (loc_q.to_carry && alu_write) carry_d = alu_bit;
      else                             carry_d = alu_carry;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      busy_q  <= 1'b0;
      carry_q <= 1'b0;
      op_q    <= '0;
      loc_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      carry_q <= carry_d;
      op_q    <= op_d;
      loc_q   <= loc_d;
    end
  end

  // ---------------- outputs ----------------
  always_comb begin
    pos_mask    = BYTE_W'(1) << loc_q.pos;
    mem_rd_en   = accept & ~req_loc.to_carry;
    mem_rd_addr = req_loc.byte_addr;
    mem_wr_en   = busy_q & alu_write & ~loc_q.to_carry;
    mem_wr_addr = loc_q.byte_addr;
    mem_wr_mask = pos_mask;
    mem_wr_data = (mem_rd_data & ~pos_mask) | (alu_bit ? pos_mask : '0);
    busy        = busy_q;
    done        = busy_q;
    bit_out     = busy_q & old_bit;
    carry       = carry_q;
  end

  // ---------------- assertions ----------------
  a_r3_busy_follows_accept: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (req_valid && !busy) |=> busy);
  a_r3_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n_sync)
    busy |=> !busy);
  a_r3_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n_sync)
    busy |-> !mem_rd_en);
  a_r11_write_only_on_done: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mem_wr_en |-> done);
  a_r4_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mem_wr_en |-> ($countones(mem_wr_mask) == 1));
  a_r4_other_bits_kept: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mem_wr_en |-> (((mem_wr_data ^ mem_rd_data) & ~mem_wr_mask) == '0));
  a_r7_take_clears: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mem_wr_en && op_q == OP_TAKE) |-> ((mem_wr_data & mem_wr_mask) == '0));
  a_r6_carry_only_at_done: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !done |=> $stable(carry));
  a_r9_no_read_of_carry: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mem_rd_en |-> (req_bit != CARRY_ADDR));
endmodule

// File: tb/bitproc_core_test.sv
module bitproc_core_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [3:0] req_op;
  logic [7:0] req_bit;
  logic       busy, mem_rd_en, mem_wr_en, done, bit_out, carry;
  logic [7:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_mask, mem_wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitproc_core uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_bit(req_bit),
    .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_mask(mem_wr_mask),
    .mem_wr_data(mem_wr_data), .done(done), .bit_out(bit_out), .carry(carry)
  );

  // data memory seen by the design
  logic [7:0] ram [256];
  logic [7:0] rd_q;
  assign mem_rd_data = rd_q;
  always @(posedge clk) begin
    if (mem_rd_en) rd_q <= ram[mem_rd_addr];
    if (mem_wr_en) ram[mem_wr_addr] <= (ram[mem_wr_addr] & ~mem_wr_mask) | (mem_wr_data & mem_wr_mask);
  end

  // reference model
  logic [7:0] ref_ram [256];
  int  m_busy, m_carry, m_op, m_bit;
  int  checks = 0, fails = 0;
  bit  finished = 0;

  function automatic int byte_of(int a);
    return (a < 128) ? (32 + a / 8) : (a - a % 8);
  endfunction

  function automatic int old_of(int a);
    if (a == 'hD7) return m_carry;
    return (ref_ram[byte_of(a)] >> (a % 8)) & 1;
  endfunction

  function automatic string tag_of(int op, int a);
    if (a == 'hD7) return "R9";
    case (op)
      0, 1, 2: return "R4";
      4:       return "R5";
      3, 5, 6, 7, 8: return "R6";
      9:       return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // model advances on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_carry = 0;
    end else if (m_busy != 0) begin
      int ob, nb, wr, b;
      ob = old_of(m_bit); nb = ob; wr = 0;
      case (m_op)
        0: begin wr = 1; nb = 1; end
        1: begin wr = 1; nb = 0; end
        2: begin wr = 1; nb = 1 - ob; end
        4: begin wr = 1; nb = m_carry; end
        9: begin wr = 1; nb = 0; end
        3: m_carry = ob;
        5: m_carry = m_carry & ob;
        6: m_carry = m_carry | ob;
        7: m_carry = m_carry & (1 - ob);
        8: m_carry = m_carry | (1 - ob);
        default: ;
      endcase
      if (wr != 0) begin
        if (m_bit == 'hD7) m_carry = nb;
        else begin
          b = byte_of(m_bit);
          ref_ram[b][m_bit % 8] = nb[0];
        end
      end
      m_busy = 0;
    end else if (req_valid) begin
      m_busy = 1; m_op = int'(req_op); m_bit = int'(req_bit);
    end
  end

  // compare all outputs against the model (called away from the edge)
  task automatic compare();
    if (m_busy == 0) begin
      bit erd;
      erd = req_valid && (req_bit != 8'hD7);
      chk(busy == 1'b0, "R3", "busy", busy, 0);
      chk(done == 1'b0, "R11", "done", done, 0);
      chk(mem_wr_en == 1'b0, "R3", "wr_en idle", mem_wr_en, 0);
      chk(mem_rd_en == erd, req_bit == 8'hD7 ? "R9" : "R3", "rd_en", mem_rd_en, erd);
      if (erd)
        chk(mem_rd_addr == 8'(byte_of(int'(req_bit))), req_bit[7] ? "R2" : "R1",
            "rd_addr", mem_rd_addr, byte_of(int'(req_bit)));
    end else begin
      int ob, ewr, nb, b;
      string t;
      t  = tag_of(m_op, m_bit);
      ob = old_of(m_bit);
      ewr = (m_bit != 'hD7) && (m_op inside {0, 1, 2, 4, 9});
      nb = (m_op == 0) ? 1 : (m_op == 2) ? 1 - ob : (m_op == 4) ? m_carry : 0;
      chk(busy == 1'b1, "R3", "busy", busy, 1);
      chk(done == 1'b1, "R11", "done", done, 1);
      chk(mem_rd_en == 1'b0, "R3", "rd_en while busy", mem_rd_en, 0);
      chk(int'(bit_out) == ob, (m_op == 9) ? "R7" : "R11", "bit_out", bit_out, ob);
      chk(int'(mem_wr_en) == ewr, t, "wr_en", mem_wr_en, ewr);
      if (ewr != 0) begin
        logic [7:0] exp_b;
        b = byte_of(m_bit);
        exp_b = ref_ram[b];
        exp_b[m_bit % 8] = nb[0];
        chk(mem_wr_addr == 8'(b), m_bit < 128 ? "R1" : "R2", "wr_addr", mem_wr_addr, b);
        chk(mem_wr_mask == 8'(1 << (m_bit % 8)), t, "wr_mask", mem_wr_mask, 1 << (m_bit % 8));
        chk(mem_wr_data == exp_b, t, "wr_data", mem_wr_data, exp_b);
      end
    end
    chk(int'(carry) == m_carry, (m_bit == 'hD7) ? "R9" : "R6", "carry", carry, m_carry);
  endtask

  task automatic step(logic v, logic [3:0] op, logic [7:0] a);
    @(negedge clk);
    compare();
    req_valid = v; req_op = op; req_bit = a;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] dir_addr [12];
    dir_addr = '{8'h00, 8'h07, 8'h08, 8'h7F, 8'h80, 8'h87, 8'hD3, 8'hD4, 8'hD7, 8'hE7, 8'hF8, 8'hFF};
    for (int i = 0; i < 256; i++) begin
      ram[i] = 8'((i * 29 + 7) & 255);
      ref_ram[i] = 8'((i * 29 + 7) & 255);
    end
    rd_q = '0; m_busy = 0; m_carry = 0; m_op = 0; m_bit = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_bit = '0;
    // R10: reset state
    repeat (3) begin
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R10", "busy/done in reset", {busy, done}, 0);
      chk(mem_wr_en == 1'b0, "R10", "wr_en in reset", mem_wr_en, 0);
      chk(carry == 1'b0, "R10", "carry in reset", carry, 0);
    end
    rst_n = 1'b1;
    repeat (5) step(1'b0, 4'd0, 8'h00);
    // directed: every op on every boundary address (R1, R2, R4-R9, R11)
    for (int i = 0; i < 12; i++)
      for (int op = 0; op < 16; op++) begin
        step(1'b1, 4'(op), dir_addr[i]);
        step(1'b0, 4'(op), dir_addr[i]);
      end
    // R3: request held high during busy must be ignored; mixed random stream
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      a = (n % 7 == 0) ? 8'hD7 : 8'($urandom_range(0, 255));
      step(($urandom_range(0, 3) != 0), 4'($urandom_range(0, 15)), a);
    end
    repeat (3) step(1'b0, 4'd0, 8'h00);
    // final memory image must match the model
    for (int i = 0; i < 256; i++)
      chk(ram[i] == ref_ram[i], "R4", "memory image", ram[i], ref_ram[i]);
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule